// File: doc/BRIEF.md
# Transfer-Snooping Accumulator Register

This block is a 32-bit data register that watches data-transfer beats as they pass by. A beat can carry a per-transfer snoop flag. When that flag is set, the register folds the beat's data into its own contents. A 4-bit mode input selects how the data is folded: as a modulo-2^32 sum, or as one 32-bit step of a reflected CRC-32. The arithmetic is therefore triggered by data movement. Software loads an operand through the register port. Each later snooped copy then adds to or hashes into that operand.

A per-beat swap flag reverses the byte order of the beat data before it is folded. This lets a copy move the most significant byte of a word into the least significant byte position. The register can also be loaded and read directly through a simple register port. If a port write and a snooped beat arrive in the same cycle, the port write wins.

The next-value logic uses a three-way fold selector (`FOLD_NONE`, `FOLD_ADD`, `FOLD_CRC`), decoded each cycle from the beat qualifiers and the mode code.
- `FOLD_NONE` is chosen when no valid snooped beat is present, or when the mode code is unrecognised.
- `FOLD_ADD` is chosen for code 0xF.
- `FOLD_CRC` is chosen for code 0x0.

A port write overrides every selector value.

Top module: `snoop_accum`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the read data is zero.
- R2: When `reg_wr` is high at a clock edge, `reg_rdata` equals `reg_wdata` after that edge.
- R3: `reg_rdata` always presents the register's current value, and it stays stable across idle cycles.
- R4: With mode code 0xF, a beat with `beat_valid` and `beat_snoop` both high sets the register to its old value plus the beat data, modulo 2^32.
- R5: With mode code 0x0, a snooped beat sets the register to one reflected CRC-32 step of the beat data, using polynomial 0xEDB88320 with no inversion. The step is: XOR the data into the register, then apply 32 shift-right steps, XORing in the polynomial whenever the bit shifted out is 1.
- R6: A beat with `beat_snoop` low, or with `beat_valid` low, leaves the register unchanged.
- R7: With `beat_swap` high, the beat's bytes are reversed before folding. Bits 7:0 move to bits 31:24, bits 15:8 move to bits 23:16, and so on.
- R8: A port write in the same cycle as a snooped beat loads `reg_wdata`, and the beat is dropped.
- R9: Mode codes other than 0x0 and 0xF leave the register unchanged on snooped beats.
- R10: In add mode, a snooped beat whose data equals the register's value doubles the register, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_valid | input | 1 | A transfer beat is present |
| beat_data | input | 32 | Data of the beat |
| beat_snoop | input | 1 | The beat is to be folded into the register |
| beat_swap | input | 1 | Reverse the byte order of the beat data |
| mode | input | 4 | Fold mode: 0xF add, 0x0 CRC-32, others hold |
| reg_wr | input | 1 | Direct register write strobe |
| reg_wdata | input | 32 | Direct register write value |
| reg_rdata | output | 32 | Current register value |

## Verification
The read port shows the register directly. Any wrong fold, wrong byte lane or missed priority therefore appears on `reg_rdata` one cycle after the faulty beat. Because every later fold depends on the stored value, such an error also persists and compounds. The bench sweeps all sixteen mode codes, every swap and snoop combination, and chains of beats. It compares each cycle against an arithmetic model, so a fault is reported in the cycle it first becomes visible.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    localparam int unsigned SNP_DATA_W = 32;
    localparam int unsigned SNP_MODE_W = 4;
    localparam logic [SNP_MODE_W-1:0] CODE_ADD = 4'hF;
    localparam logic [SNP_MODE_W-1:0] CODE_CRC = 4'h0;
    localparam logic [SNP_DATA_W-1:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [1:0] {
        FOLD_NONE = 2'd0,
        FOLD_ADD  = 2'd1,
        FOLD_CRC  = 2'd2
    } fold_e;
endpackage

// File: rtl/snp_bswap.sv
module snp_bswap #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              swap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int unsigned NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] reversed;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign reversed[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
    end

    assign dout = swap ? reversed : din;
endmodule

// File: rtl/snp_crc_step.sv
module snp_crc_step #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] POLY = 32'hEDB88320
) (
    input  logic [DATA_W-1:0] state,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] next
);
    always_comb begin
        logic [DATA_W-1:0] c;
        c = state ^ data;
        for (int i = 0; i < int'(DATA_W); i++) begin
            c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        next = c;
    end
endmodule

// File: rtl/snoop_accum.sv
module snoop_accum
    import snoop_pkg::*;
#(
    parameter int unsigned DATA_W = SNP_DATA_W,
    parameter int unsigned MODE_W = SNP_MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              beat_snoop,
    input  logic              beat_swap,
    input  logic [MODE_W-1:0] mode,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_d;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] crc_next;
    fold_e             fold;

    snp_bswap #(.DATA_W(DATA_W)) u_swap (
        .swap (beat_swap),
        .din  (beat_data),
        .dout (lane_data)
    );

    snp_crc_step #(.DATA_W(DATA_W), .POLY(CRC_POLY[DATA_W-1:0])) u_crc (
        .state (acc_q),
        .data  (lane_data),
        .next  (crc_next)
    );

    // Fold selection: which operation the current beat requests.
    always_comb begin
        fold = FOLD_NONE;
        if (beat_valid && beat_snoop) begin
            if (mode == CODE_ADD[MODE_W-1:0])      fold = FOLD_ADD;
            else if (mode == CODE_CRC[MODE_W-1:0]) fold = FOLD_CRC;
            else                                   fold = FOLD_NONE;
        end
    end

    // Next value: a port write overrides any fold.
    always_comb begin
        acc_d = acc_q;
        if (reg_wr) begin
            acc_d = reg_wdata;
        end else begin
            unique case (fold)
                FOLD_ADD:  acc_d = acc_q + lane_data;
                FOLD_CRC:  acc_d = crc_next;
                FOLD_NONE: acc_d = acc_q;
                default:   acc_d = acc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign reg_rdata = acc_q;
endmodule

// File: rtl/snoop_accum_chk.sv
module snoop_accum_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        beat_valid,
    input logic [31:0] beat_data,
    input logic        beat_snoop,
    input logic        beat_swap,
    input logic [3:0]  mode,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata
);
    logic [31:0] swapped;
    assign swapped = {beat_data[7:0], beat_data[15:8], beat_data[23:16], beat_data[31:24]};

    p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> reg_rdata == 32'd0);

    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata == $past(reg_wdata));

    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !(beat_valid && beat_snoop)) |=> $stable(reg_rdata));

    p_add_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && beat_valid && beat_snoop && !beat_swap && mode == 4'hF)
        |=> reg_rdata == $past(reg_rdata) + $past(beat_data));

    p_add_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && beat_valid && beat_snoop && beat_swap && mode == 4'hF)
        |=> reg_rdata == $past(reg_rdata) + $past(swapped));

    p_other_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && mode != 4'hF && mode != 4'h0) |=> $stable(reg_rdata));
endmodule

bind snoop_accum snoop_accum_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .beat_snoop (beat_snoop),
    .beat_swap  (beat_swap),
    .mode       (mode),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
);

// File: tb/snoop_accum_tb.sv
module snoop_accum_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_valid = 1'b0;
    logic [31:0] beat_data = '0;
    logic        beat_snoop = 1'b0;
    logic        beat_swap = 1'b0;
    logic [3:0]  mode = 4'hF;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    snoop_accum u_dut (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_data(beat_data),
        .beat_snoop(beat_snoop), .beat_swap(beat_swap), .mode(mode),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] ref_swap(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    // Serial form of the reflected CRC: one data bit per shift.
    function automatic logic [31:0] ref_crc(input logic [31:0] s, input logic [31:0] d);
        logic [31:0] c;
        logic fb;
        c = s;
        for (int i = 0; i < 32; i++) begin
            fb = c[0] ^ d[i];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_checks++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, reg_rdata, exp);
        end
    endtask

    // Apply one cycle of stimulus, then sample two ns after the edge.
    task automatic cyc(input logic wr, input logic [31:0] wd, input logic v, input logic sn,
                       input logic sw, input logic [3:0] m, input logic [31:0] d);
        reg_wr = wr; reg_wdata = wd; beat_valid = v; beat_snoop = sn;
        beat_swap = sw; mode = m; beat_data = d;
        @(posedge clk); #2;
        reg_wr = 1'b0; beat_valid = 1'b0; beat_snoop = 1'b0;
    endtask

    task automatic load(input logic [31:0] v);
        cyc(1'b1, v, 1'b0, 1'b0, 1'b0, 4'hF, 32'h0);
        model = v;
        check("R2 write", model);
    endtask

    initial begin
        #3000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] ld;
        repeat (3) @(posedge clk);
        #2;
        check("R1 in reset", 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 after release", 32'h0);

        // R2/R3: write a walking-one pattern and its inverse.
        for (int i = 0; i < 32; i++) begin
            load(32'h1 << i);
            load(~(32'h1 << i));
        end
        // R3: idle cycles keep the value.
        repeat (3) begin
            @(posedge clk); #2;
            check("R3 idle hold", model);
        end

        // R4 and R7: add chains, plain and swapped.
        load(32'h0000_0000);
        for (int i = 0; i < 64; i++) begin
            d = 32'h9E37_79B9 * (i + 1) ^ (i << 3);
            cyc(1'b0, 32'h0, 1'b1, 1'b1, i[0], 4'hF, d);
            model = model + (i[0] ? ref_swap(d) : d);
            check(i[0] ? "R7 swapped add" : "R4 add", model);
        end
        load(32'hFFFF_FFFF);
        cyc(1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 4'hF, 32'h2);
        check("R4 wraparound", 32'h1);
        model = 32'h1;

        // R7: a high byte moved to the low byte.
        load(32'h0);
        cyc(1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 4'hF, 32'hAB00_0000);
        check("R7 high byte to low", 32'h0000_00AB);

        // R5: CRC chains, with and without swap.
        load(32'h0);
        for (int i = 0; i < 48; i++) begin
            d = 32'h0123_4567 + i * 32'h1111_1111;
            cyc(1'b0, 32'h0, 1'b1, 1'b1, i[1], 4'h0, d);
            model = ref_crc(model, i[1] ? ref_swap(d) : d);
            check("R5 crc step", model);
        end

        // R6: all valid/snoop combinations except both high, in both live modes.
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 3; k++) begin
                cyc(1'b0, 32'h0, k[0], k[1], 1'b0, m[0] ? 4'hF : 4'h0, 32'hDEAD_BEEF);
                check("R6 no snoop", model);
            end
        end

        // R9: sweep of every mode code with a snooped beat.
        ld = 32'h1357_9BDF;
        for (int m = 0; m < 16; m++) begin
            load(ld);
            d = 32'h0F0F_0F0F ^ m;
            cyc(1'b0, 32'h0, 1'b1, 1'b1, 1'b0, m[3:0], d);
            if (m == 15)     model = ld + d;
            else if (m == 0) model = ref_crc(ld, d);
            else             model = ld;
            check(m == 15 ? "R4 mode sweep" : (m == 0 ? "R5 mode sweep" : "R9 other mode"), model);
        end

        // R8: write wins over a simultaneous snooped beat.
        for (int m = 0; m < 2; m++) begin
            load(32'h5555_AAAA);
            cyc(1'b1, 32'h0BAD_F00D, 1'b1, 1'b1, 1'b0, m[0] ? 4'hF : 4'h0, 32'h7777_7777);
            model = 32'h0BAD_F00D;
            check("R8 write priority", model);
        end

        // R10: snooping the register's own value doubles it.
        for (int i = 0; i < 8; i++) begin
            ld = 32'h1234_5678 + 32'h2000_0001 * i;
            load(ld);
            cyc(1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 4'hF, reg_rdata);
            model = ld << 1;
            check("R10 doubling", model);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule